// File: doc/BRIEF.md
# Banked Stack Pointer Control Unit

This unit holds the two stack pointers of a small microcontroller core, a 2-bit control register and a one-bit interrupt mask. Only one stack pointer register is physically in use at any time (the active copy). The other stack sits in an alternate copy. A single stack-select flag, kept only inside the control register, decides which stack the active copy holds. Whenever that flag changes value, the two copies exchange contents. The same flag steers every read and write of the stack pointers by register number, so a read of the control register always names the stack that is really in use.

Software-style access goes through a combinational read port and a clocked write port, both addressed by a 5-bit register number. The number codes are 8 for the main stack, 9 for the process stack, 16 for the mask and 20 for control. Two strobes model the exception path. The entry strobe returns a link value and forces the main stack. The return strobe applies a requested stack selection. Both strobes use the same exchange logic as a control write.

Top module: `spbank_top`

## Requirements
- R1: After reset, reads of registers 8, 9, 16 and 20 all return zero, and `wrErr` is low.
- R2: Register 20 holds two bits: bit 1 is the stack-select flag (0 = main stack, 1 = process stack) and bit 0 is the unprivileged flag. A write keeps only bits [1:0]; a read returns them with every other bit zero.
- R3: When the stack-select flag takes a new value, the active and alternate copies exchange contents at that clock edge; when it keeps its value, no exchange happens.
- R4: A read of register 8 returns the main stack pointer and a read of register 9 returns the process stack pointer, whichever copy holds each.
- R5: A write to register 8 or 9 updates the copy that currently holds that stack, leaving the other stack unchanged.
- R6: A read of register 16 returns the mask in bit 0 with all other bits zero; a write loads the mask from bit 0 of the data.
- R7: A write to register 20 exchanges the stacks first when the select flag changes, then stores the masked value, so both stacks read back with their old values afterwards.
- R8: While `excEntry` is high, `linkVal` equals 0xFFFFFFF1, with bit 2 set if the stack-select flag is 1 and bit 3 set if `excActive` is low.
- R9: An exception entry clears the stack-select flag (exchanging if needed), leaves bit 0 unchanged, and the change is visible on the next read of register 20.
- R10: An exception return sets the stack-select flag to `retSel` through the same exchange logic, visible on the next read of register 20.
- R11: Reads of any other register number return zero. Writes to any other number change no state and raise `wrErr` for exactly the one cycle after the write edge.
- R12: An exception strobe in the same cycle as a register write wins: the write is dropped and raises no error. Entry wins over return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdNum | input | 5 | Register number for the combinational read |
| rdData | output | 32 | Read data |
| wrEn | input | 1 | Write strobe |
| wrNum | input | 5 | Register number for the write |
| wrData | input | 32 | Write data |
| excEntry | input | 1 | Exception entry strobe |
| excActive | input | 1 | High when an exception is already being handled |
| linkVal | output | 32 | Link value for the current entry |
| excReturn | input | 1 | Exception return strobe |
| retSel | input | 1 | Requested stack-select value on return |
| wrErr | output | 1 | One-cycle pulse after a write to an unknown number |

## Verification
The hardest case to reach from the ports has the process stack active with distinct main and process values, followed by an exception entry and a later return. Only there does a copy routed by the wrong select, a missing exchange, or a stale control readback show up as a wrong value. The stimulus first loads distinct values into both stacks, switches to the process stack through a control write, and rewrites both stacks in that state. It then issues entry and return strobes and reads back both stacks and control after each one. A same-cycle entry and write checks the priority rule.

// File: rtl/spbank_pkg.sv
package spbank_pkg;
  localparam int REG_MSP  = 8;
  localparam int REG_PSP  = 9;
  localparam int REG_MASK = 16;
  localparam int REG_CTRL = 20;

  // Strobes from control to datapath for one clock edge
  typedef struct packed {
    logic swap;      // exchange active and alternate copies
    logic setSel;    // load stack-select flag
    logic selVal;
    logic setPriv;   // load unprivileged flag
    logic privVal;
    logic wrActive;  // load active copy from write data
    logic wrAlt;     // load alternate copy from write data
    logic wrMask;
    logic maskVal;
    logic err;       // write to unknown number
  } dpStrobes_t;
endpackage

// File: rtl/spbank_ctrl.sv
module spbank_ctrl
  import spbank_pkg::*;
#(
  parameter int NUM_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              wrEn,
  input  logic [NUM_W-1:0]  wrNum,
  input  logic [1:0]        wrLow,
  input  logic              excEntry,
  input  logic              excActive,
  input  logic              excReturn,
  input  logic              retSel,
  input  logic              spSel,
  output dpStrobes_t        stb,
  output logic [DATA_W-1:0] linkVal
);
  localparam logic [DATA_W-1:0] LINK_BASE = DATA_W'(32'hFFFF_FFF1);

  always_comb begin
    stb = '0;
    if (excEntry) begin
      stb.setSel = 1'b1;
      stb.selVal = 1'b0;
      stb.swap   = spSel;
    end else if (excReturn) begin
      stb.setSel = 1'b1;
      stb.selVal = retSel;
      stb.swap   = (retSel != spSel);
    end else if (wrEn) begin
      case (wrNum)
        NUM_W'(REG_MSP): begin
          stb.wrAlt    = spSel;
          stb.wrActive = !spSel;
        end
        NUM_W'(REG_PSP): begin
          stb.wrActive = spSel;
          stb.wrAlt    = !spSel;
        end
        NUM_W'(REG_MASK): begin
          stb.wrMask  = 1'b1;
          stb.maskVal = wrLow[0];
        end
        NUM_W'(REG_CTRL): begin
          stb.swap    = (wrLow[1] != spSel);
          stb.setSel  = 1'b1;
          stb.selVal  = wrLow[1];
          stb.setPriv = 1'b1;
          stb.privVal = wrLow[0];
        end
        default: stb.err = 1'b1;
      endcase
    end
  end

  always_comb begin
    linkVal = LINK_BASE;
    if (spSel)      linkVal = linkVal | DATA_W'(4);
    if (!excActive) linkVal = linkVal | DATA_W'(8);
  end
endmodule

// File: rtl/spbank_dp.sv
module spbank_dp
  import spbank_pkg::*;
#(
  parameter int NUM_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_W-1:0]  rdNum,
  output logic [DATA_W-1:0] rdData,
  output logic              spSel,
  output logic              wrErr
);
  logic [DATA_W-1:0] activeSp;
  logic [DATA_W-1:0] altSp;
  logic [1:0]        ctrlReg;
  logic              maskReg;
  logic              errReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeSp <= '0;
      altSp    <= '0;
      ctrlReg  <= '0;
      maskReg  <= 1'b0;
      errReg   <= 1'b0;
    end else begin
      errReg <= stb.err;
      if (stb.swap) begin
        activeSp <= altSp;
        altSp    <= activeSp;
      end else begin
        if (stb.wrActive) activeSp <= wrData;
        if (stb.wrAlt)    altSp    <= wrData;
      end
      if (stb.setSel)  ctrlReg[1] <= stb.selVal;
      if (stb.setPriv) ctrlReg[0] <= stb.privVal;
      if (stb.wrMask)  maskReg    <= stb.maskVal;
    end
  end

  assign spSel = ctrlReg[1];
  assign wrErr = errReg;

  always_comb begin
    case (rdNum)
      NUM_W'(REG_MSP):  rdData = spSel ? altSp : activeSp;
      NUM_W'(REG_PSP):  rdData = spSel ? activeSp : altSp;
      NUM_W'(REG_MASK): rdData = DATA_W'(maskReg);
      NUM_W'(REG_CTRL): rdData = DATA_W'(ctrlReg);
      default:          rdData = '0;
    endcase
  end
endmodule

// File: rtl/spbank_top.sv
module spbank_top
  import spbank_pkg::*;
#(
  parameter int NUM_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_W-1:0]  rdNum,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [NUM_W-1:0]  wrNum,
  input  logic [DATA_W-1:0] wrData,
  input  logic              excEntry,
  input  logic              excActive,
  output logic [DATA_W-1:0] linkVal,
  input  logic              excReturn,
  input  logic              retSel,
  output logic              wrErr
);
  dpStrobes_t stb;
  logic       spSel;

  spbank_ctrl #(.NUM_W(NUM_W), .DATA_W(DATA_W)) ctrl_i (
    .wrEn(wrEn), .wrNum(wrNum), .wrLow(wrData[1:0]),
    .excEntry(excEntry), .excActive(excActive),
    .excReturn(excReturn), .retSel(retSel),
    .spSel(spSel), .stb(stb), .linkVal(linkVal)
  );

  spbank_dp #(.NUM_W(NUM_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .rdNum(rdNum), .rdData(rdData), .spSel(spSel), .wrErr(wrErr)
  );
endmodule

// File: rtl/spbank_chk.sv
module spbank_chk
  import spbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input dpStrobes_t        stb,
  input logic [DATA_W-1:0] activeSp,
  input logic [DATA_W-1:0] altSp,
  input logic [1:0]        ctrlReg,
  input logic              maskReg
);
  // R3
  swap_on_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[1] != $past(ctrlReg[1])) |->
      (activeSp == $past(altSp) && altSp == $past(activeSp)));

  // R3
  hold_when_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(ctrlReg[1]) && !$past(stb.wrActive) && !$past(stb.wrAlt)) |->
      ($stable(activeSp) && $stable(altSp)));

  // R10
  sel_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.setSel |=> (ctrlReg[1] == $past(stb.selVal)));

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrMask |=> (maskReg == $past(stb.maskVal)));

  // R7
  swap_write_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.swap && (stb.wrActive || stb.wrAlt)));
endmodule

bind spbank_dp spbank_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .stb(stb), .activeSp(activeSp),
  .altSp(altSp), .ctrlReg(ctrlReg), .maskReg(maskReg)
);

// File: tb/spbank_top_tb_top.sv
module spbank_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  rdNum = '0;
  logic [31:0] rdData;
  logic        wrEn = 1'b0;
  logic [4:0]  wrNum = '0;
  logic [31:0] wrData = '0;
  logic        excEntry = 1'b0;
  logic        excActive = 1'b0;
  logic [31:0] linkVal;
  logic        excReturn = 1'b0;
  logic        retSel = 1'b0;
  logic        wrErr;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  localparam logic [31:0] A = 32'h2000_1000, B = 32'h2000_2000;
  localparam logic [31:0] C = 32'h2000_3000, D = 32'h2000_4000;

  always #10 clk = ~clk;

  spbank_top dut_i (
    .clk(clk), .rstN(rstN), .rdNum(rdNum), .rdData(rdData),
    .wrEn(wrEn), .wrNum(wrNum), .wrData(wrData),
    .excEntry(excEntry), .excActive(excActive), .linkVal(linkVal),
    .excReturn(excReturn), .retSel(retSel), .wrErr(wrErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readChk(input string req, input int num, input logic [31:0] exp);
    rdNum = 5'(num);
    #1;
    check(req, rdData, exp);
  endtask

  // drive at negedge, let one posedge take it, return at next negedge
  task automatic doWrite(input int num, input logic [31:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrNum = 5'(num); wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic testReset();
    readChk("R1 msp", 8, 0);
    readChk("R1 psp", 9, 0);
    readChk("R1 mask", 16, 0);
    readChk("R1 ctrl", 20, 0);
    check("R1 wrErr", 32'(wrErr), 0);
  endtask

  task automatic testStacks();
    doWrite(8, A);
    readChk("R5 msp sel0", 8, A);
    readChk("R5 psp untouched", 9, 0);
    doWrite(9, B);
    readChk("R4 psp sel0", 9, B);
    readChk("R4 msp sel0", 8, A);
    doWrite(20, 32'h2);
    readChk("R2 ctrl sel", 20, 32'h2);
    readChk("R7 msp after swap", 8, A);
    readChk("R7 psp after swap", 9, B);
    doWrite(8, C);
    readChk("R5 msp sel1", 8, C);
    readChk("R5 psp kept sel1", 9, B);
    doWrite(9, D);
    readChk("R5 psp sel1", 9, D);
    readChk("R4 msp sel1", 8, C);
  endtask

  task automatic testCtrlMask();
    doWrite(20, 32'hFFFF_FFFF);
    readChk("R2 ctrl masked", 20, 32'h3);
    readChk("R3 no swap msp", 8, C);
    readChk("R3 no swap psp", 9, D);
  endtask

  task automatic testEntry();
    @(negedge clk);
    excActive = 1'b0; excEntry = 1'b1;
    #1;
    check("R8 link thread proc", linkVal, 32'hFFFF_FFFD);
    @(negedge clk);
    excEntry = 1'b0;
    readChk("R9 ctrl after entry", 20, 32'h1);
    readChk("R9 msp after entry", 8, C);
    readChk("R9 psp after entry", 9, D);
    @(negedge clk);
    excActive = 1'b1; excEntry = 1'b1;
    #1;
    check("R8 link handler main", linkVal, 32'hFFFF_FFF1);
    @(negedge clk);
    excEntry = 1'b0; excActive = 1'b0;
    readChk("R9 ctrl stays", 20, 32'h1);
  endtask

  task automatic testReturn();
    @(negedge clk);
    excReturn = 1'b1; retSel = 1'b1;
    @(negedge clk);
    excReturn = 1'b0;
    readChk("R10 ctrl after return", 20, 32'h3);
    readChk("R10 psp after return", 9, D);
    readChk("R10 msp after return", 8, C);
    @(negedge clk);
    excReturn = 1'b1; retSel = 1'b1;
    @(negedge clk);
    excReturn = 1'b0;
    readChk("R10 same sel no swap", 9, D);
    // entry beats return in the same cycle
    @(negedge clk);
    excReturn = 1'b1; excEntry = 1'b1; retSel = 1'b1;
    @(negedge clk);
    excReturn = 1'b0; excEntry = 1'b0;
    readChk("R12 entry over return", 20, 32'h1);
    readChk("R12 msp intact", 8, C);
  endtask

  task automatic testPriority();
    @(negedge clk);
    excEntry = 1'b1; wrEn = 1'b1; wrNum = 5'd8; wrData = 32'hDEAD_0000;
    @(negedge clk);
    excEntry = 1'b0; wrEn = 1'b0;
    readChk("R12 write dropped", 8, C);
    check("R12 no error", 32'(wrErr), 0);
    @(negedge clk);
    excEntry = 1'b1; wrEn = 1'b1; wrNum = 5'd3; wrData = 32'h1;
    @(negedge clk);
    excEntry = 1'b0; wrEn = 1'b0;
    check("R12 unknown dropped no error", 32'(wrErr), 0);
  endtask

  task automatic testMask();
    doWrite(16, 32'h5);
    readChk("R6 mask set", 16, 32'h1);
    doWrite(16, 32'h2);
    readChk("R6 mask clear", 16, 32'h0);
    doWrite(16, 32'hFFFF_FFFF);
    readChk("R6 mask set again", 16, 32'h1);
  endtask

  task automatic testUnknown();
    readChk("R11 read unknown", 3, 0);
    readChk("R11 read unknown 31", 31, 0);
    doWrite(3, 32'h1234_5678);
    check("R11 err pulse", 32'(wrErr), 1);
    readChk("R11 msp unchanged", 8, C);
    readChk("R11 ctrl unchanged", 20, 32'h1);
    readChk("R11 mask unchanged", 16, 32'h1);
    @(negedge clk);
    check("R11 err one cycle", 32'(wrErr), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStacks();
    testCtrlMask();
    testEntry();
    testReturn();
    testPriority();
    testMask();
    testUnknown();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule